// File: doc/BRIEF.md
# Chainable Serial Result Port for a 16-bit Converter

This block is the slave-side serial output of a converter. When a conversion finishes, the block loads the result into a shift register. A host that drives an external serial clock then reads the word one bit per clock, most significant bit first. The host picks which clock edge moves the data with a polarity select. Each shift also takes the level of a daisy input into the low end of the register. After the port's own word has gone out, the word of an upstream port follows on the same line with no gap, so several ports can share one data wire.

The external clock is sampled by the system clock through a two-stage synchroniser, and its edges are found in the system clock domain. The output line carries data only while both the chip-select and the read-enable inputs are low. A read counts as finished after 16 shift edges. If a new result arrives while a read has started but not finished, the partial word is discarded and the register is reloaded. The block then raises an error pulse lasting one system clock.

Top module: `adc_serial_slave`

## Requirements
- R1: While `rst_n` is low, `sdout` and `rd_error` are low, the shift register is cleared and the edge count is zero.
- R2: `sdout` shows the register's most significant bit only while `cs_n` and `rd_n` are both low. At all other times it is driven low.
- R3: A one-cycle `conv_done` loads `conv_data` into the register, so bit 15 of the new word is the first bit on `sdout`.
- R4: With `inv_sclk` low, a rising edge of `sclk_in` shifts the register left by one place. The shift takes effect on the third `clk` rising edge, counting the edge that first samples the new level.
- R5: With `inv_sclk` high, the falling edge of `sclk_in` does the shift, with the same latency as in R4, and the rising edge has no effect.
- R6: On every shift, the `sdin` level sampled at that moment enters bit 0. After 16 shifts, `sdout` presents the first `sdin` bit that was shifted in.
- R7: Clock edges that occur while `cs_n` or `rd_n` is high leave the register unchanged.
- R8: Shift edges since the read was enabled are counted, saturating at 16. A high `cs_n` or a `conv_done` clears the count.
- R9: If `conv_done` arrives while reading is enabled and the count is between 1 and 15, `rd_error` is high for exactly one `clk` cycle, the cycle after `conv_done`, and the register holds the new word.
- R10: If `conv_done` arrives with a count of 0 or 16, or while reading is disabled, no error pulse is produced.
- R11: When `conv_done` and a shift edge fall in the same cycle, the load wins and no shift is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_in | input | 1 | External serial clock, asynchronous |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read enable, active low |
| sdin | input | 1 | Daisy-chain serial input |
| inv_sclk | input | 1 | 0: shift on rising edge, 1: shift on falling edge |
| conv_done | input | 1 | One-cycle strobe that marks a new result |
| conv_data | input | 16 | New conversion result |
| sdout | output | 1 | Serial data output |
| rd_error | output | 1 | One-cycle pulse on an overtaken partial read |

## Verification
Assertions check the following properties on every cycle:
- the error pulse lasts one cycle and is caused by a new result during an enabled read;
- a new result is loaded in the following cycle;
- the register holds while reading is disabled;
- the count stays within bounds and clears when chip select is high;
- a completed read never raises an error.

Some behaviour can only be shown by the bench's scenarios, which run against a reference model cycle by cycle:
- the actual bit order on the line, including the upstream word that follows the local one;
- the synchroniser latency;
- the effect of the edge-polarity select;
- the collision of a new result with a shift edge.

// File: rtl/adc_serial_slave.sv
module adc_serial_slave #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk_in,
  input  logic             cs_n,
  input  logic             rd_n,
  input  logic             sdin,
  input  logic             inv_sclk,
  input  logic             conv_done,
  input  logic [WIDTH-1:0] conv_data,
  output logic             sdout,
  output logic             rd_error
);
  localparam int CW = $clog2(WIDTH + 1);
  localparam logic [CW-1:0] FULL = CW'(WIDTH);

  logic [2:0]       sync_q;
  logic [WIDTH-1:0] shreg;
  logic [CW-1:0]    cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], sclk_in};

  wire rise       = sync_q[1] & ~sync_q[2];
  wire fall       = ~sync_q[1] & sync_q[2];
  wire shift_edge = inv_sclk ? fall : rise;
  wire read_en    = ~cs_n & ~rd_n;
  wire partial    = read_en && (cnt != '0) && (cnt != FULL);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                     shreg <= '0;
    else if (conv_done)             shreg <= conv_data;
    else if (shift_edge && read_en) shreg <= {shreg[WIDTH-2:0], sdin};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                                     cnt <= '0;
    else if (conv_done || cs_n)                     cnt <= '0;
    else if (shift_edge && read_en && cnt != FULL)  cnt <= cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rd_error <= 1'b0;
    else        rd_error <= conv_done && partial;

  assign sdout = read_en & shreg[WIDTH-1];

  p_err_one_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_error |=> !rd_error);
  p_err_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_error |-> $past(conv_done) && $past(read_en));
  p_no_err_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && cnt == FULL) |=> !rd_error);
  p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> shreg == $past(conv_data));
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!read_en && !conv_done) |=> $stable(shreg));
  p_count_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL);
  p_cs_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> cnt == '0);
endmodule

// File: tb/adc_serial_slave_tb.sv
module adc_serial_slave_tb;
  logic clk = 0, rst_n = 0, sclk_in = 0, cs_n = 1, rd_n = 1, sdin = 0;
  logic inv_sclk = 0, conv_done = 0;
  logic [15:0] conv_data = '0;
  logic sdout, rd_error;
  int checks = 0, fails = 0, err_seen = 0;
  string cur_req = "R1";

  adc_serial_slave #(.WIDTH(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .sclk_in(sclk_in), .cs_n(cs_n), .rd_n(rd_n),
    .sdin(sdin), .inv_sclk(inv_sclk), .conv_done(conv_done),
    .conv_data(conv_data), .sdout(sdout), .rd_error(rd_error));

  always #2.5 clk = ~clk;

  bit   hist[4];
  bit [15:0] m_reg;
  int   m_cnt;
  bit   m_err;

  always @(posedge clk) begin
    bit en, ed;
    en = !cs_n && !rd_n;
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) hist[i] = 0;
      m_reg <= '0; m_cnt <= 0; m_err <= 0;
    end else begin
      for (int i = 3; i > 0; i--) hist[i] = hist[i-1];
      hist[0] = sclk_in;
      ed = inv_sclk ? (!hist[2] && hist[3]) : (hist[2] && !hist[3]);
      m_err <= conv_done && en && m_cnt > 0 && m_cnt < 16;
      if (conv_done) begin
        m_reg <= conv_data; m_cnt <= 0;
      end else begin
        if (ed && en) m_reg <= {m_reg[14:0], sdin};
        if (cs_n) m_cnt <= 0;
        else if (ed && en && m_cnt < 16) m_cnt <= m_cnt + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    bit en;
    #1;
    en = !cs_n && !rd_n;
    if (rd_error) err_seen++;
    chk(sdout == (en ? m_reg[15] : 1'b0), cur_req, sdout, en ? m_reg[15] : 0);
    chk(rd_error == m_err, cur_req, rd_error, m_err);
  end

  task automatic wait_clk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic sclk_pulse(input bit d);
    sdin = d;
    sclk_in = 1; wait_clk(4);
    sclk_in = 0; wait_clk(4);
  endtask

  task automatic load(input logic [15:0] d);
    conv_data = d; conv_done = 1; wait_clk(1); conv_done = 0; wait_clk(1);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL R1 watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int e0;
    bit [15:0] pat;
    wait_clk(3);
    cur_req = "R1";
    chk(sdout == 0, "R1", sdout, 0);
    chk(rd_error == 0, "R1", rd_error, 0);
    rst_n = 1; wait_clk(2);

    cur_req = "R3";
    cs_n = 0; rd_n = 0;
    load(16'hA5C3);
    chk(sdout == 1, "R3", sdout, 1);

    cur_req = "R4";
    sclk_in = 1; wait_clk(2);
    chk(sdout == 1, "R4", sdout, 1);
    wait_clk(1);
    chk(sdout == 0, "R4", sdout, 0);
    sclk_in = 0; wait_clk(4);

    cur_req = "R6";
    pat = 16'hB00F;
    for (int i = 15; i >= 1; i--) sclk_pulse(pat[i]);
    for (int i = 0; i < 16; i++) begin
      if (i == 1) chk(sdout == pat[15], "R6", sdout, pat[15]);
      sclk_pulse(pat[14 - (i % 15)]);
    end

    cur_req = "R2";
    rd_n = 1; wait_clk(1);
    chk(sdout == 0, "R2", sdout, 0);
    rd_n = 0;

    cur_req = "R5";
    inv_sclk = 1;
    load(16'h4A61);
    sclk_in = 1; wait_clk(4);
    chk(sdout == 0, "R5", sdout, 0);
    sclk_in = 0; wait_clk(4);
    chk(sdout == 1, "R5", sdout, 1);
    for (int i = 0; i < 6; i++) sclk_pulse(i[0]);
    inv_sclk = 0;

    cur_req = "R7";
    load(16'h8001);
    cs_n = 1;
    for (int i = 0; i < 5; i++) sclk_pulse(0);
    cs_n = 0; wait_clk(1);
    chk(sdout == 1, "R7", sdout, 1);

    cur_req = "R9";
    for (int i = 0; i < 5; i++) sclk_pulse(1);
    e0 = err_seen;
    load(16'h7FFF);
    wait_clk(3);
    chk(err_seen - e0 == 1, "R9", err_seen - e0, 1);
    chk(sdout == 0, "R9", sdout, 0);

    cur_req = "R10";
    for (int i = 0; i < 16; i++) sclk_pulse(0);
    e0 = err_seen;
    load(16'hFFFF);
    wait_clk(3);
    chk(err_seen - e0 == 0, "R10", err_seen - e0, 0);

    cur_req = "R8";
    for (int i = 0; i < 4; i++) sclk_pulse(0);
    cs_n = 1; wait_clk(2); cs_n = 0; wait_clk(1);
    e0 = err_seen;
    load(16'h1234);
    wait_clk(3);
    chk(err_seen - e0 == 0, "R8", err_seen - e0, 0);

    cur_req = "R11";
    load(16'hC000);
    sclk_in = 1; wait_clk(2);
    conv_data = 16'h9000; conv_done = 1; wait_clk(1); conv_done = 0;
    wait_clk(2);
    chk(sdout == 1, "R11", sdout, 1);
    sclk_in = 0; wait_clk(4);
    sclk_pulse(0);
    chk(sdout == 0, "R11", sdout, 0);

    wait_clk(4);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule